// File: doc/BRIEF.md
# Tape Transport Start/Stop Sequencer

This block holds the single run flag that engages the tape transport clutch and releases its brake. It listens to a set of one-cycle command pulses. Any ordinary start command opens a memory-clear window and arms a short delayed start. The flag is set only when that delay runs out, so the memory has time to empty before characters can reach the read path. A bad-spot command arms a separate, much longer delayed start that leaves memory alone. A group of stop commands and a global clear drop the flag.

Every delay is given in microseconds and turned into clock ticks through a ticks-per-microsecond parameter. The block models the time the tape needs to come up to speed only as the gap between the run flag rising and the end of the memory-clear window. While the flag is low, the block reports that the read path is blocked. Each accepted ordinary start also emits a one-cycle pulse that resets the downstream character-count error latch.

Top module: `tape_drive_sequencer`

## Requirements
- R1: After reset, `drive` is 0, `not_reading` is 1, `clear_busy` is 0 and `err_clr` is 0.
- R2: An ordinary start is any set bit of `start_cmd` (seven sources: load, initial start, read start, multiline end, forward, backward, rewind). Once it is sampled at clock edge E, `clear_busy` is 1 from E until edge E+CLEAR_TICKS, where it falls.
- R3: An ordinary start sampled at edge E sets `drive` at edge E+START_TICKS and not earlier.
- R4: An accepted ordinary start sampled at edge E drives `err_clr` high for exactly the one cycle after E.
- R5: `bad_spot` sampled at edge E sets `drive` at edge E+BAD_TICKS, and `clear_busy` stays 0.
- R6: A set bit of `stop_cmd` (six sources: load end, read-cycle end, rewind released, backward released, end of tape, bad-spot end) clears `drive` at the next edge.
- R7: `gen_clear` clears `drive`, cancels every pending delayed start and ends the memory-clear window at the next edge. No delayed start fires after it.
- R8: If a stop and a delayed-start expiry fall on the same edge, `drive` stays 0.
- R9: A new ordinary start that arrives while one is pending restarts the delay. The flag then rises START_TICKS after the newer request only.
- R10: `not_reading` is always the complement of `drive`.
- R11: A start that arrives together with `gen_clear` is ignored: no `err_clr` pulse and no clear window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_cmd | input | 7 | One-cycle ordinary start pulses, one bit per source |
| bad_spot | input | 1 | One-cycle bad-spot restart pulse |
| stop_cmd | input | 6 | One-cycle stop pulses, one bit per source |
| gen_clear | input | 1 | Global clear pulse |
| drive | output | 1 | Run flag: clutch engaged, brake released |
| not_reading | output | 1 | Read path blocked (brake active) |
| clear_busy | output | 1 | Memory-clear window in progress |
| err_clr | output | 1 | One-cycle error-latch reset pulse |

## Verification
The assertions expect command inputs to be single-cycle pulses. They also expect the delay parameters to satisfy START_TICKS < CLEAR_TICKS with both at least 2. The bench applies each command for exactly one clock and uses scaled delays (20, 44 and 160 ticks) that keep this ordering. It places some pulses on purpose on the edge where a timer expires, and others inside a pending delay, so the priority rules are exercised at their exact cycles.

// File: rtl/tape_seq_pkg.sv
`timescale 1ns/1ps
package tape_seq_pkg;
  localparam int unsigned N_START = 7;
  localparam int unsigned N_STOP  = 6;

  function automatic int unsigned us_to_ticks(int unsigned us, int unsigned per_us);
    return us * per_us;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/tape_delay_timer.sv
`timescale 1ns/1ps
module tape_delay_timer #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cancel,
  input  logic load,
  output logic busy,
  output logic fire
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (cancel)        cnt <= '0;
    else if (load)          cnt <= CNT_W'(TICKS);
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  // last cycle of the count: the consumer acts on the following edge
  assign fire = (cnt == CNT_W'(1)) && !cancel && !load;

  a_r7_cancel_empties: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> !busy);
  a_r9_reload_full: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !cancel) |=> (cnt == CNT_W'(TICKS)));
endmodule

// File: rtl/tape_drive_sequencer.sv
`timescale 1ns/1ps
module tape_drive_sequencer
  import tape_seq_pkg::*;
#(
  parameter int unsigned TICKS_PER_US = 100,
  parameter int unsigned START_US     = 2500,
  parameter int unsigned CLEAR_US     = 5500,
  parameter int unsigned BAD_US       = 20000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_START-1:0] start_cmd,
  input  logic               bad_spot,
  input  logic [N_STOP-1:0]  stop_cmd,
  input  logic               gen_clear,
  output logic               drive,
  output logic               not_reading,
  output logic               clear_busy,
  output logic               err_clr
);
  localparam int unsigned START_TICKS = us_to_ticks(START_US, TICKS_PER_US);
  localparam int unsigned CLEAR_TICKS = us_to_ticks(CLEAR_US, TICKS_PER_US);
  localparam int unsigned BAD_TICKS   = us_to_ticks(BAD_US, TICKS_PER_US);
  localparam int unsigned CNT_W       = $clog2(max3(START_TICKS, CLEAR_TICKS, BAD_TICKS) + 1);

  // named internal events
  logic start_ok, bad_ok, stop_any;
  logic fire_start, fire_bad, start_pending, bad_pending;

  assign start_ok = (|start_cmd) && !gen_clear;
  assign bad_ok   = bad_spot && !gen_clear;
  assign stop_any = |stop_cmd;

  tape_delay_timer #(.CNT_W(CNT_W), .TICKS(START_TICKS)) u_start_dly (
    .clk(clk), .rst_n(rst_n), .cancel(gen_clear), .load(start_ok),
    .busy(start_pending), .fire(fire_start));

  tape_delay_timer #(.CNT_W(CNT_W), .TICKS(CLEAR_TICKS)) u_clear_win (
    .clk(clk), .rst_n(rst_n), .cancel(gen_clear), .load(start_ok),
    .busy(clear_busy), .fire());

  tape_delay_timer #(.CNT_W(CNT_W), .TICKS(BAD_TICKS)) u_bad_dly (
    .clk(clk), .rst_n(rst_n), .cancel(gen_clear), .load(bad_ok),
    .busy(bad_pending), .fire(fire_bad));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       drive <= 1'b0;
    else if (gen_clear || stop_any)   drive <= 1'b0;
    else if (fire_start || fire_bad)  drive <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_clr <= 1'b0;
    else        err_clr <= start_ok;
  end

  assign not_reading = !drive;

  a_r3_rise_needs_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive) |-> $past(fire_start || fire_bad));
  a_r4_err_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |-> $past((|start_cmd) && !gen_clear));
  a_r5_clear_only_normal: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clear_busy) |-> $past(|start_cmd));
  a_r6_stop_drops: assert property (@(posedge clk) disable iff (!rst_n)
    stop_any |=> !drive);
  a_r7_gclear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    gen_clear |=> (!drive && !clear_busy && !start_pending && !bad_pending));
  a_r8_stop_beats_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_any && (fire_start || fire_bad)) |=> !drive);
  a_r10_read_block: assert property (@(posedge clk) disable iff (!rst_n)
    not_reading != drive);
endmodule

// File: tb/tape_drive_sequencer_bench.sv
`timescale 1ns/1ps
module tape_drive_sequencer_bench;
  localparam int S = 20, C = 44, B = 160;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [6:0] start_cmd = '0;
  logic bad_spot = 1'b0;
  logic [5:0] stop_cmd = '0;
  logic gen_clear = 1'b0;
  logic drive, not_reading, clear_busy, err_clr;

  int cyc = 0, total = 0, bad = 0;
  int exp_q[$];
  logic prev_drive = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tape_drive_sequencer #(.TICKS_PER_US(2), .START_US(10), .CLEAR_US(22), .BAD_US(80))
    u_tape_drive_sequencer (.clk(clk), .rst_n(rst_n), .start_cmd(start_cmd),
      .bad_spot(bad_spot), .stop_cmd(stop_cmd), .gen_clear(gen_clear),
      .drive(drive), .not_reading(not_reading), .clear_busy(clear_busy), .err_clr(err_clr));

  task automatic chk(string rq, int got, int expv);
    total++;
    if (got != expv) begin
      bad++;
      $display("FAIL %s at cycle %0d: got %0d expected %0d", rq, cyc, got, expv);
    end
  endtask

  // scoreboard monitor: every rise of drive must match the head of the queue
  always @(negedge clk) begin
    if (rst_n && drive && !prev_drive) begin
      if (exp_q.size() == 0) chk("R3 unexpected drive rise", cyc, -1);
      else chk("R3/R5/R9 drive rise cycle", cyc, exp_q.pop_front());
    end
    if (rst_n) begin
      chk("R10 not_reading", int'(not_reading), int'(!drive));
    end
    prev_drive = drive;
  end

  task automatic wait_to(int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic pulse_start(int idx, output int e);
    @(negedge clk);
    start_cmd[idx] = 1'b1;
    e = cyc + 1;
    @(negedge clk);
    start_cmd = '0;
  endtask

  task automatic pulse_stop(int idx);
    @(negedge clk);
    stop_cmd[idx] = 1'b1;
    @(negedge clk);
    stop_cmd = '0;
  endtask

  initial begin
    int e, e2;
    repeat (3) @(negedge clk);
    chk("R1 drive reset", int'(drive), 0);
    chk("R1 not_reading reset", int'(not_reading), 1);
    chk("R1 clear_busy reset", int'(clear_busy), 0);
    chk("R1 err_clr reset", int'(err_clr), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // basic start
    pulse_start(0, e);
    exp_q.push_back(e + S);
    chk("R4 err_clr pulse", int'(err_clr), 1);
    chk("R2 clear_busy on", int'(clear_busy), 1);
    chk("R3 drive not early", int'(drive), 0);
    @(negedge clk);
    chk("R4 err_clr one cycle", int'(err_clr), 0);
    wait_to(e + S - 1);
    chk("R3 drive low before delay", int'(drive), 0);
    wait_to(e + S);
    chk("R3 drive set", int'(drive), 1);
    chk("R2 clear still busy at start", int'(clear_busy), 1);
    wait_to(e + C - 1);
    chk("R2 clear busy last cycle", int'(clear_busy), 1);
    wait_to(e + C);
    chk("R2 clear window ends", int'(clear_busy), 0);

    // every stop source
    for (int k = 0; k < 6; k++) begin
      pulse_stop(k);
      chk("R6 stop clears drive", int'(drive), 0);
      pulse_start((k + 1) % 7, e);
      exp_q.push_back(e + S);
      wait_to(e + S);
      chk("R3 restart sets drive", int'(drive), 1);
    end
    pulse_stop(0);

    // bad spot
    wait_to(cyc + C);
    @(negedge clk); bad_spot = 1'b1; e = cyc + 1;
    @(negedge clk); bad_spot = 1'b0;
    exp_q.push_back(e + B);
    chk("R5 no clear window", int'(clear_busy), 0);
    chk("R5 no err pulse", int'(err_clr), 0);
    wait_to(e + S + 1);
    chk("R5 not set at short delay", int'(drive), 0);
    wait_to(e + B);
    chk("R5 drive after long delay", int'(drive), 1);
    chk("R5 clear idle", int'(clear_busy), 0);
    pulse_stop(5);

    // restart while pending
    pulse_start(3, e);
    repeat (5) @(negedge clk);
    pulse_start(5, e2);
    exp_q.push_back(e2 + S);
    wait_to(e + S);
    chk("R9 old delay ignored", int'(drive), 0);
    wait_to(e2 + S);
    chk("R9 new delay fires", int'(drive), 1);
    pulse_stop(1);

    // stop on the expiry edge
    pulse_start(2, e);
    wait_to(e + S - 1);
    stop_cmd[2] = 1'b1;
    @(negedge clk); stop_cmd = '0;
    chk("R8 stop wins over expiry", int'(drive), 0);
    repeat (10) @(negedge clk);
    chk("R8 drive stays low", int'(drive), 0);

    // gen clear cancels
    wait_to(cyc + C);
    pulse_start(6, e);
    repeat (5) @(negedge clk);
    gen_clear = 1'b1; @(negedge clk); gen_clear = 1'b0;
    chk("R7 clear window cancelled", int'(clear_busy), 0);
    wait_to(e + C + 5);
    chk("R7 pending start cancelled", int'(drive), 0);

    // gen clear with simultaneous start
    @(negedge clk); gen_clear = 1'b1; start_cmd[4] = 1'b1;
    @(negedge clk); gen_clear = 1'b0; start_cmd = '0;
    chk("R11 no err pulse", int'(err_clr), 0);
    chk("R11 no clear window", int'(clear_busy), 0);
    repeat (S + 5) @(negedge clk);
    chk("R11 no drive", int'(drive), 0);

    chk("R3 all expected rises seen", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5 * 150000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired at cycle %0d: got hang expected finish", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule